// File: doc/BRIEF.md
# Buffered Asynchronous Serial Port

This block is an asynchronous serial port with a small byte-wide register interface. The host writes bytes that the port sends as start/data/parity/stop frames on `txd`. Frames arriving on `rxd` are turned back into bytes that the host reads. A 16-bit divisor sets the bit rate. Each bit lasts sixteen ticks of an internal oversampling strobe. A divisor below four is clamped to four and flagged in status.

A control bit picks the buffering. In buffered mode each direction has a 64-entry queue. In direct mode each direction holds exactly one byte. Changing the mode empties both directions. Receive errors are kept in sticky status bits: parity, overrun, framing and line break. The host can poll status, or enable an interrupt.

Two strobes request DMA service: one when the transmit side has room, one when received data waits. Flow control uses one input and one output. `cts_n` holds back the start of new frames. `rts_n` tells the far end whether the receive side still has room.

Top module: `uart_fifo_port`

Register map (`host_addr`):
- 0: data. A write queues a byte for transmit; a read takes the oldest received byte.
- 1: interrupt enable. Bit 0 = received data, bit 1 = transmit queue empty, bit 2 = receive error.
- 2: control. Bit 0 = buffered mode, bit 1 = RTS enable, bit 2 = parity on, bit 3 = even parity, bit 4 = DMA enable.
- 3: divisor, low byte.
- 4: divisor, high byte.
- 5: status.

Status bits:
- Bit 0: data ready.
- Bit 1: overrun.
- Bit 2: parity error.
- Bit 3: framing error.
- Bit 4: break.
- Bit 5: transmit room.
- Bit 6: transmitter idle.
- Bit 7: divisor clamped.

Read data appears on `host_rdata` one clock after the `host_rd` strobe.

## Requirements
- R1: After reset, status (address 5) reads 0x60, `txd` is 1, `irq`, `tx_dreq` and `rx_dreq` are 0, and `rts_n` is 1. Whenever the transmitter is idle, `txd` is 1.
- R2: One serial bit lasts 16*max(D,4) clocks, where D is the divisor at addresses 3 and 4. Status bit 7 is 1 while D is below 4.
- R3: A transmitted frame is one 0 start bit, then 8 data bits LSB first, then a parity bit if control bit 2 is set, then one 1 stop bit. The parity bit makes the count of ones even when control bit 3 is 1, and odd when it is 0.
- R4: In buffered mode (control bit 0 = 1) each direction holds 64 bytes. Status bit 5 goes to 0 once 64 bytes wait to be sent. A 65th received byte is dropped and sets overrun (status bit 1), while the first 64 read back in order.
- R5: In direct mode (control bit 0 = 0) each direction holds one byte. A second received byte, arriving before the first is read, is dropped and sets overrun; the first byte is kept.
- R6: A low level on `rxd` starts a frame only if it is still low at the 8th oversampling tick. A shorter low pulse produces no byte.
- R7: A received parity bit that does not match the configured parity sets status bit 2, and the byte is still stored.
- R8: A 0 stop bit sets status bit 3. The receiver then waits for `rxd` to return to 1 before it looks for a new start bit.
- R9: A frame that is all zeros, including the stop bit, sets status bit 4 and stores a single 0x00 byte, however long the line stays low.
- R10: Status bits 1 to 4 are cleared by a read of status, unless a new event sets them in the same cycle.
- R11: No frame starts while `cts_n` is 1. A pending byte goes out once `cts_n` returns to 0.
- R12: With control bit 4 set, `tx_dreq` is 1 exactly when the transmit side has room, and `rx_dreq` is 1 exactly when received data waits. Both are 0 when the bit is clear.
- R13: `irq` is the OR of three terms, each gated by its interrupt-enable bit: data ready, transmit queue empty, and any receive error.
- R14: With control bit 1 set, `rts_n` is 0 while the receive side has room. Room means fewer than 56 bytes in buffered mode, or an empty holding byte in direct mode. Otherwise `rts_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 3 | Register select |
| host_wdata | input | 8 | Write data |
| host_wr | input | 1 | Write strobe, one cycle |
| host_rd | input | 1 | Read strobe, one cycle |
| host_rdata | output | 8 | Read data, valid the cycle after `host_rd` |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| cts_n | input | 1 | Clear-to-send, active low |
| rts_n | output | 1 | Request-to-send, active low |
| irq | output | 1 | Interrupt request |
| tx_dreq | output | 1 | DMA request for transmit data |
| rx_dreq | output | 1 | DMA request for receive data |

## Verification
The hardest case to reach is overrun at full buffered depth. It needs 65 complete frames to arrive while the host reads nothing, and only the last of them may be lost. The bench drives `rxd` from its own bit-level serializer, without reading, then checks two things. First, overrun and the flow-control line have both turned. Second, all 64 stored bytes drain in order. The single-byte break and the rejected short start pulse are reached the same way: the bench holds the line low for chosen lengths of time.

// File: rtl/uart_pkg.sv
`timescale 1ns/1ps
package uart_pkg;
    localparam int DIV_W = 16;

    localparam logic [2:0] ADDR_DATA = 3'd0;
    localparam logic [2:0] ADDR_IER  = 3'd1;
    localparam logic [2:0] ADDR_CTRL = 3'd2;
    localparam logic [2:0] ADDR_DIVL = 3'd3;
    localparam logic [2:0] ADDR_DIVH = 3'd4;
    localparam logic [2:0] ADDR_STAT = 3'd5;

    typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} tx_state_e;
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_WAIT_HIGH} rx_state_e;

    typedef struct packed {
        logic par_en;
        logic par_even;
    } frame_cfg_t;
endpackage

// File: rtl/uart_tick_gen.sv
`timescale 1ns/1ps
module uart_tick_gen #(
    parameter int DIV_W   = 16,
    parameter int MIN_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick,
    output logic             clamped
);
    logic [DIV_W-1:0] eff_div;
    logic [DIV_W-1:0] cnt_d, cnt_q;

    assign clamped = divisor < DIV_W'(MIN_DIV);
    assign eff_div = clamped ? DIV_W'(MIN_DIV) : divisor;
    assign tick    = cnt_q >= eff_div - 1'b1;

    always_comb begin
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/uart_fifo.sv
`timescale 1ns/1ps
module uart_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             single,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);
    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
    } fifo_t;

    fifo_t q, n;
    logic [WIDTH-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign empty   = q.cnt == '0;
    assign full    = single ? !empty : (q.cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[q.rptr];
    assign count   = q.cnt;

    always_comb begin
        n = q;
        if (flush) begin
            n = '0;
        end else begin
            if (do_push) n.wptr = q.wptr + 1'b1;
            if (do_pop)  n.rptr = q.rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   n.cnt = q.cnt + 1'b1;
                2'b01:   n.cnt = q.cnt - 1'b1;
                default: n.cnt = q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[q.wptr] <= wdata;
    end
endmodule

// File: rtl/uart_tx.sv
`timescale 1ns/1ps
module uart_tx
    import uart_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16,
    localparam int CNT_W = $clog2(OSR),
    localparam int BIT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cts_ok,
    input  frame_cfg_t        cfg,
    input  logic              avail,
    input  logic [DATA_W-1:0] data,
    output logic              pop,
    output logic              txd,
    output logic              busy
);
    typedef struct packed {
        tx_state_e         st;
        logic [CNT_W-1:0]  sub;
        logic [BIT_W-1:0]  bitn;
        logic [DATA_W-1:0] sh;
        logic              par;
        logic              txd;
    } tx_t;

    localparam logic [CNT_W-1:0] LAST_SUB = CNT_W'(OSR - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    tx_t q, n;

    assign txd  = q.txd;
    assign busy = q.st != TX_IDLE;

    always_comb begin
        n   = q;
        pop = 1'b0;
        if (q.st == TX_IDLE) begin
            n.txd = 1'b1;
            if (tick && avail && cts_ok) begin
                pop    = 1'b1;
                n.st   = TX_START;
                n.sub  = '0;
                n.sh   = data;
                n.par  = (^data) ^ ~cfg.par_even;
                n.txd  = 1'b0;
            end
        end else if (tick) begin
            if (q.sub != LAST_SUB) begin
                n.sub = q.sub + 1'b1;
            end else begin
                n.sub = '0;
                case (q.st)
                    TX_START: begin
                        n.st   = TX_DATA;
                        n.bitn = '0;
                        n.txd  = q.sh[0];
                    end
                    TX_DATA: begin
                        if (q.bitn == LAST_BIT) begin
                            n.st  = cfg.par_en ? TX_PAR : TX_STOP;
                            n.txd = cfg.par_en ? q.par : 1'b1;
                        end else begin
                            n.bitn = q.bitn + 1'b1;
                            n.sh   = q.sh >> 1;
                            n.txd  = q.sh[1];
                        end
                    end
                    TX_PAR: begin
                        n.st  = TX_STOP;
                        n.txd = 1'b1;
                    end
                    default: begin
                        n.st  = TX_IDLE;
                        n.txd = 1'b1;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= TX_IDLE;
            q.txd <= 1'b1;
        end else begin
            q <= n;
        end
    end
endmodule

// File: rtl/uart_rx.sv
`timescale 1ns/1ps
module uart_rx
    import uart_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16,
    localparam int CNT_W = $clog2(OSR),
    localparam int BIT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  frame_cfg_t        cfg,
    output logic              done,
    output logic [DATA_W-1:0] dbyte,
    output logic              pe,
    output logic              fe,
    output logic              brk
);
    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  sub;
        logic [BIT_W-1:0]  bitn;
        logic [DATA_W-1:0] sh;
        logic              par_bit;
        logic              done;
        logic [DATA_W-1:0] dbyte;
        logic              pe;
        logic              fe;
        logic              brk;
    } rx_t;

    localparam logic [CNT_W-1:0] LAST_SUB = CNT_W'(OSR - 1);
    localparam logic [CNT_W-1:0] MID_SUB  = CNT_W'(OSR / 2 - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    rx_t q, n;
    logic exp_par, all_zero;

    assign exp_par  = (^q.sh) ^ ~cfg.par_even;
    assign all_zero = (q.sh == '0) && !(cfg.par_en && q.par_bit);
    assign done  = q.done;
    assign dbyte = q.dbyte;
    assign pe    = q.pe;
    assign fe    = q.fe;
    assign brk   = q.brk;

    always_comb begin
        n      = q;
        n.done = 1'b0;
        case (q.st)
            RX_IDLE: begin
                if (tick && !rxd) begin
                    n.st  = RX_START;
                    n.sub = '0;
                end
            end
            RX_START: begin
                if (tick) begin
                    if (q.sub != MID_SUB) begin
                        n.sub = q.sub + 1'b1;
                    end else if (!rxd) begin
                        n.st   = RX_DATA;
                        n.sub  = '0;
                        n.bitn = '0;
                    end else begin
                        n.st = RX_IDLE;
                    end
                end
            end
            RX_WAIT_HIGH: begin
                if (rxd) n.st = RX_IDLE;
            end
            default: begin
                if (tick) begin
                    if (q.sub != LAST_SUB) begin
                        n.sub = q.sub + 1'b1;
                    end else begin
                        n.sub = '0;
                        case (q.st)
                            RX_DATA: begin
                                n.sh = {rxd, q.sh[DATA_W-1:1]};
                                if (q.bitn == LAST_BIT) n.st = cfg.par_en ? RX_PAR : RX_STOP;
                                else                    n.bitn = q.bitn + 1'b1;
                            end
                            RX_PAR: begin
                                n.par_bit = rxd;
                                n.st      = RX_STOP;
                            end
                            default: begin
                                n.done  = 1'b1;
                                n.dbyte = q.sh;
                                n.fe    = !rxd;
                                n.brk   = !rxd && all_zero;
                                n.pe    = cfg.par_en && (q.par_bit != exp_par);
                                n.st    = rxd ? RX_IDLE : RX_WAIT_HIGH;
                            end
                        endcase
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= RX_IDLE;
        end else begin
            q <= n;
        end
    end
endmodule

// File: rtl/uart_fifo_port.sv
`timescale 1ns/1ps
module uart_fifo_port
    import uart_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int OSR        = 16,
    parameter int MIN_DIV    = 4,
    parameter int RTS_MARGIN = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] host_addr,
    input  logic [7:0] host_wdata,
    input  logic       host_wr,
    input  logic       host_rd,
    output logic [7:0] host_rdata,
    input  logic       rxd,
    output logic       txd,
    input  logic       cts_n,
    output logic       rts_n,
    output logic       irq,
    output logic       tx_dreq,
    output logic       rx_dreq
);
    typedef struct packed {
        logic [7:0]       ier;
        logic [7:0]       ctrl;
        logic [DIV_W-1:0] div;
        logic             ovr;
        logic             pe;
        logic             fe;
        logic             brk;
        logic [7:0]       rdata;
        logic [1:0]       rx_s;
        logic [1:0]       cts_s;
    } port_t;

    port_t q, n;

    logic tick, div_clamped, cts_ok, rxd_s;
    logic tx_push, tx_pop, tx_full, tx_empty, tx_busy;
    logic rx_pop, rx_push, rx_full, rx_empty, rx_done, rx_pe, rx_fe, rx_brk;
    logic flush, rd_stat, tx_idle, rx_almost, any_err;
    logic [7:0] tx_data, rx_rdata, rx_byte, status;
    logic [CW-1:0] tx_count, rx_count;
    frame_cfg_t cfg;

    assign cfg      = '{par_en: q.ctrl[2], par_even: q.ctrl[3]};
    assign cts_ok   = !q.cts_s[1];
    assign rxd_s    = q.rx_s[1];
    assign tx_push  = host_wr && host_addr == ADDR_DATA;
    assign rx_pop   = host_rd && host_addr == ADDR_DATA;
    assign rd_stat  = host_rd && host_addr == ADDR_STAT;
    assign flush    = host_wr && host_addr == ADDR_CTRL && host_wdata[0] != q.ctrl[0];
    assign rx_push  = rx_done && !rx_full;
    assign tx_idle  = tx_empty && !tx_busy;
    assign any_err  = q.ovr | q.pe | q.fe | q.brk;
    assign status   = {div_clamped, tx_idle, !tx_full, q.brk, q.fe, q.pe, q.ovr, !rx_empty};
    assign rx_almost = q.ctrl[0] ? (rx_count >= CW'(DEPTH - RTS_MARGIN)) : !rx_empty;

    assign host_rdata = q.rdata;
    assign rts_n   = !(q.ctrl[1] && !rx_almost);
    assign irq     = (q.ier[0] && !rx_empty) || (q.ier[1] && tx_empty) || (q.ier[2] && any_err);
    assign tx_dreq = q.ctrl[4] && !tx_full;
    assign rx_dreq = q.ctrl[4] && !rx_empty;

    uart_tick_gen #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .divisor(q.div), .tick(tick), .clamped(div_clamped)
    );

    uart_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_txf (
        .clk(clk), .rst_n(rst_n), .flush(flush), .single(!q.ctrl[0]),
        .push(tx_push), .wdata(host_wdata), .pop(tx_pop), .rdata(tx_data),
        .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    uart_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_rxf (
        .clk(clk), .rst_n(rst_n), .flush(flush), .single(!q.ctrl[0]),
        .push(rx_push), .wdata(rx_byte), .pop(rx_pop), .rdata(rx_rdata),
        .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    uart_tx #(.DATA_W(8), .OSR(OSR)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cts_ok(cts_ok), .cfg(cfg),
        .avail(!tx_empty), .data(tx_data), .pop(tx_pop), .txd(txd), .busy(tx_busy)
    );

    uart_rx #(.DATA_W(8), .OSR(OSR)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd_s), .cfg(cfg),
        .done(rx_done), .dbyte(rx_byte), .pe(rx_pe), .fe(rx_fe), .brk(rx_brk)
    );

    always_comb begin
        n       = q;
        n.rx_s  = {q.rx_s[0], rxd};
        n.cts_s = {q.cts_s[0], cts_n};
        n.ovr   = (rd_stat ? 1'b0 : q.ovr) | (rx_done & rx_full);
        n.pe    = (rd_stat ? 1'b0 : q.pe)  | (rx_done & rx_pe);
        n.fe    = (rd_stat ? 1'b0 : q.fe)  | (rx_done & rx_fe);
        n.brk   = (rd_stat ? 1'b0 : q.brk) | (rx_done & rx_brk);
        if (host_wr) begin
            case (host_addr)
                ADDR_IER:  n.ier       = host_wdata;
                ADDR_CTRL: n.ctrl      = host_wdata;
                ADDR_DIVL: n.div[7:0]  = host_wdata;
                ADDR_DIVH: n.div[15:8] = host_wdata;
                default:   ;
            endcase
        end
        if (host_rd) begin
            case (host_addr)
                ADDR_DATA: n.rdata = rx_rdata;
                ADDR_IER:  n.rdata = q.ier;
                ADDR_CTRL: n.rdata = q.ctrl;
                ADDR_DIVL: n.rdata = q.div[7:0];
                ADDR_DIVH: n.rdata = q.div[15:8];
                ADDR_STAT: n.rdata = status;
                default:   n.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.div   <= DIV_W'(MIN_DIV);
            q.rx_s  <= 2'b11;
            q.cts_s <= 2'b11;
        end else begin
            q <= n;
        end
    end
endmodule

// File: rtl/uart_port_chk.sv
`timescale 1ns/1ps
module uart_port_chk #(
    parameter int DEPTH = 64,
    parameter int CW    = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          txd,
    input logic          tx_busy,
    input logic          cts_ok,
    input logic          tx_full,
    input logic          tx_dreq,
    input logic [CW-1:0] rx_count,
    input logic          fifo_mode,
    input logic          rx_push,
    input logic          rx_brk,
    input logic [7:0]    rx_byte
);
    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    // R11
    cts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> $past(cts_ok));

    // R12
    tx_dreq_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dreq |-> !tx_full);

    // R4
    rx_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CW'(DEPTH));

    // R5
    single_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_mode |-> rx_count <= CW'(1));

    // R9
    break_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_brk) |-> rx_byte == 8'h00);
endmodule

bind uart_fifo_port uart_port_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
    .clk(clk), .rst_n(rst_n), .txd(txd), .tx_busy(tx_busy), .cts_ok(cts_ok),
    .tx_full(tx_full), .tx_dreq(tx_dreq), .rx_count(rx_count),
    .fifo_mode(q.ctrl[0]), .rx_push(rx_push), .rx_brk(rx_brk), .rx_byte(rx_byte)
);

// File: tb/uart_fifo_port_tb.sv
`timescale 1ns/1ps
module uart_fifo_port_tb_top;
    localparam int BITC = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_rdata;
    logic rxd_drv = 1'b1, loop = 1'b0, cts_n = 1'b0;
    logic txd, rts_n, irq, tx_dreq, rx_dreq, rxd_w;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;
    assign rxd_w = loop ? txd : rxd_drv;

    uart_fifo_port dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
        .rxd(rxd_w), .txd(txd), .cts_n(cts_n), .rts_n(rts_n), .irq(irq),
        .tx_dreq(tx_dreq), .rx_dreq(rx_dreq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); host_addr = a; host_rd = 1'b1;
        @(negedge clk); host_rd = 1'b0; d = host_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_bit(input logic v, input int len);
        rxd_drv = v;
        repeat (len) @(negedge clk);
    endtask

    task automatic send_rx(input logic [7:0] b, input bit par_on, input logic pbit, input logic stopb);
        put_bit(1'b0, BITC);
        for (int i = 0; i < 8; i++) put_bit(b[i], BITC);
        if (par_on) put_bit(pbit, BITC);
        put_bit(stopb, BITC);
        rxd_drv = 1'b1;
    endtask

    // Decodes one frame on txd; the byte's bit 0 must be 1 so the start length is measurable.
    task automatic grab_tx(input int bitc, input bit par_on, output logic [7:0] b,
                           output int low_len, output logic pbit, output logic stopb);
        int w = 0;
        while (txd === 1'b1 && w < 40000) begin @(negedge clk); w++; end
        low_len = 0;
        while (txd === 1'b0 && low_len < 1000) begin @(negedge clk); low_len++; end
        repeat (bitc / 2) @(negedge clk);
        b[0] = txd;
        for (int i = 1; i < 8; i++) begin repeat (bitc) @(negedge clk); b[i] = txd; end
        pbit = 1'b0;
        if (par_on) begin repeat (bitc) @(negedge clk); pbit = txd; end
        repeat (bitc) @(negedge clk);
        stopb = txd;
        repeat (bitc) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] s;
        reg_rd(3'd5, s);
        chk("R1 status after reset", s, 8'h60);
        chk("R1 txd idle", txd, 1'b1);
        chk("R1 irq", irq, 1'b0);
        chk("R1 dreqs", {tx_dreq, rx_dreq}, 2'b00);
        chk("R1 rts_n", rts_n, 1'b1);
    endtask

    task automatic t_divisor;
        logic [7:0] s, b; int len; logic p, st;
        reg_wr(3'd3, 8'd2);
        reg_rd(3'd5, s);
        chk("R2 clamp flag", s[7], 1'b1);
        reg_wr(3'd2, 8'h0C);
        reg_wr(3'd0, 8'h55);
        grab_tx(BITC, 1'b1, b, len, p, st);
        chk("R2 clamped bit time", len, BITC);
        chk("R3 data even parity", b, 8'h55);
        chk("R3 even parity bit", p, 1'b0);
        chk("R3 stop bit", st, 1'b1);
        reg_wr(3'd2, 8'h04);
        reg_wr(3'd3, 8'd8);
        reg_rd(3'd5, s);
        chk("R2 clamp flag clear", s[7], 1'b0);
        reg_wr(3'd0, 8'h01);
        grab_tx(2 * BITC, 1'b1, b, len, p, st);
        chk("R2 divisor 8 bit time", len, 2 * BITC);
        chk("R3 odd parity bit", p, 1'b0);
        chk("R3 data odd parity", b, 8'h01);
        reg_wr(3'd3, 8'd4);
        reg_wr(3'd2, 8'h00);
    endtask

    task automatic t_cts;
        logic [7:0] b; int len; logic p, st; int lows = 0;
        cts_n = 1'b1;
        reg_wr(3'd0, 8'hA5);
        for (int i = 0; i < 1500; i++) begin @(negedge clk); if (txd !== 1'b1) lows++; end
        chk("R11 held while cts_n high", lows, 0);
        cts_n = 1'b0;
        grab_tx(BITC, 1'b0, b, len, p, st);
        chk("R11 sent after cts_n low", b, 8'hA5);
    endtask

    task automatic t_loop_fifo;
        logic [7:0] s, d;
        reg_wr(3'd2, 8'h01);
        loop = 1'b1;
        reg_wr(3'd0, 8'h11);
        reg_wr(3'd0, 8'h23);
        reg_wr(3'd0, 8'h35);
        idle(3 * 10 * BITC + 200);
        reg_rd(3'd5, s);
        chk("R3 loopback data ready", s[0], 1'b1);
        reg_rd(3'd0, d); chk("R3 loopback byte 0", d, 8'h11);
        reg_rd(3'd0, d); chk("R3 loopback byte 1", d, 8'h23);
        reg_rd(3'd0, d); chk("R3 loopback byte 2", d, 8'h35);
        reg_rd(3'd5, s);
        chk("R3 loopback drained", s[0], 1'b0);
        loop = 1'b0;
    endtask

    task automatic t_rx_fill;
        logic [7:0] s, d; int bad = 0;
        reg_wr(3'd2, 8'h03);
        idle(4);
        chk("R14 rts_n low when empty", rts_n, 1'b0);
        for (int i = 0; i < 65; i++) send_rx(8'(i * 3 + 1), 1'b0, 1'b0, 1'b1);
        idle(10);
        chk("R14 rts_n high when nearly full", rts_n, 1'b1);
        reg_rd(3'd5, s);
        chk("R4 overrun on 65th byte", s[1:0], 2'b11);
        reg_rd(3'd5, s);
        chk("R10 overrun cleared by status read", s[1], 1'b0);
        for (int i = 0; i < 64; i++) begin
            reg_rd(3'd0, d);
            if (d !== 8'(i * 3 + 1)) bad++;
        end
        chk("R4 64 bytes in order", bad, 0);
        reg_rd(3'd5, s);
        chk("R4 65th byte dropped", s[0], 1'b0);
        chk("R14 rts_n low after drain", rts_n, 1'b0);
    endtask

    task automatic t_tx_full;
        logic [7:0] s;
        cts_n = 1'b1;
        reg_wr(3'd2, 8'h11);
        chk("R12 tx_dreq with room", tx_dreq, 1'b1);
        for (int i = 0; i < 63; i++) reg_wr(3'd0, 8'(i));
        reg_rd(3'd5, s);
        chk("R4 room after 63", s[5], 1'b1);
        reg_wr(3'd0, 8'hFF);
        reg_rd(3'd5, s);
        chk("R4 no room after 64", s[5], 1'b0);
        chk("R12 tx_dreq low when full", tx_dreq, 1'b0);
        reg_wr(3'd2, 8'h10);
        reg_rd(3'd5, s);
        chk("R4 mode change empties tx", s[6:5], 2'b11);
        chk("R12 tx_dreq after flush", tx_dreq, 1'b1);
        reg_wr(3'd2, 8'h00);
        cts_n = 1'b0;
    endtask

    task automatic t_nonfifo_overrun;
        logic [7:0] s, d;
        reg_wr(3'd2, 8'h00);
        send_rx(8'h3C, 1'b0, 1'b0, 1'b1);
        send_rx(8'hC3, 1'b0, 1'b0, 1'b1);
        idle(10);
        reg_rd(3'd5, s);
        chk("R5 ready and overrun", s[1:0], 2'b11);
        reg_rd(3'd0, d);
        chk("R5 first byte kept", d, 8'h3C);
        reg_rd(3'd5, s);
        chk("R5 second byte dropped", s[0], 1'b0);
    endtask

    task automatic t_parity;
        logic [7:0] s, d;
        reg_wr(3'd2, 8'h0C);
        send_rx(8'h07, 1'b1, 1'b0, 1'b1);
        idle(10);
        reg_rd(3'd5, s);
        chk("R7 parity error set", s[2], 1'b1);
        reg_rd(3'd0, d);
        chk("R7 byte still stored", d, 8'h07);
        send_rx(8'h07, 1'b1, 1'b1, 1'b1);
        idle(10);
        reg_rd(3'd5, s);
        chk("R10 R7 parity clear on good frame", s[2], 1'b0);
        reg_rd(3'd0, d);
        reg_wr(3'd2, 8'h00);
    endtask

    task automatic t_framing;
        logic [7:0] s, d;
        send_rx(8'h81, 1'b0, 1'b0, 1'b0);
        idle(BITC);
        reg_rd(3'd5, s);
        chk("R8 framing set, no break", s[4:3], 2'b01);
        reg_rd(3'd0, d);
        chk("R8 byte", d, 8'h81);
        reg_rd(3'd5, s);
        chk("R8 no extra frame", s[0], 1'b0);
    endtask

    task automatic t_break;
        logic [7:0] s, d;
        reg_wr(3'd2, 8'h01);
        put_bit(1'b0, 30 * BITC);
        put_bit(1'b1, 3 * BITC);
        reg_rd(3'd5, s);
        chk("R9 break flag and data", {s[4], s[0]}, 2'b11);
        reg_rd(3'd0, d);
        chk("R9 zero byte", d, 8'h00);
        reg_rd(3'd5, s);
        chk("R9 single byte only", s[0], 1'b0);
        reg_wr(3'd2, 8'h00);
    endtask

    task automatic t_glitch;
        logic [7:0] s, d;
        put_bit(1'b0, 16);
        put_bit(1'b1, 12 * BITC);
        reg_rd(3'd5, s);
        chk("R6 short low ignored", s[0], 1'b0);
        send_rx(8'h5A, 1'b0, 1'b0, 1'b1);
        idle(10);
        reg_rd(3'd0, d);
        chk("R6 next frame received", d, 8'h5A);
    endtask

    task automatic t_irq_dma;
        logic [7:0] d;
        reg_wr(3'd2, 8'h10);
        reg_wr(3'd1, 8'h01);
        chk("R13 irq idle", irq, 1'b0);
        chk("R12 rx_dreq idle", rx_dreq, 1'b0);
        send_rx(8'h42, 1'b0, 1'b0, 1'b1);
        idle(10);
        chk("R13 irq on data", irq, 1'b1);
        chk("R12 rx_dreq on data", rx_dreq, 1'b1);
        reg_rd(3'd0, d);
        chk("R13 irq after read", irq, 1'b0);
        chk("R12 rx_dreq after read", rx_dreq, 1'b0);
        reg_wr(3'd1, 8'h02);
        idle(2);
        chk("R13 irq tx empty", irq, 1'b1);
        reg_wr(3'd1, 8'h00);
        reg_wr(3'd2, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(5);
        t_reset();
        t_divisor();
        t_cts();
        t_loop_fifo();
        t_rx_fill();
        t_tx_full();
        t_nonfifo_overrun();
        t_parity();
        t_framing();
        t_break();
        t_glitch();
        t_irq_dma();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule